// File: doc/BRIEF.md
# UART Receive Byte Queue

This block sits between a UART's serial deserializer and its register bank. Each byte that the deserializer recovers is offered on a one-cycle push strobe together with its line-error flags. The block holds the bytes in a circular queue (sixteen entries by default) and hands them out one per read strobe. It reports how full the queue is, whether data is waiting, and a sticky line-error word that clears when it is read. For each accepted byte, and for each fault (a dropped byte or a read from an empty queue), it sends a one-cycle pulse to the interrupt logic.

A control word selects how bytes are held. With the queue enabled, bytes are stored in order and read back in the same order. With the queue disabled, a single holding register keeps only the most recent byte. The same control word carries a self-clearing flush bit that empties the queue.

Top module: `rxq_top`

## Requirements
- R1: After reset, the status word, data-ready, the error word, the stored control value and both event outputs are all zero, so the queue starts out disabled.
- R2: With control bit 0 set, bytes are read back in the order they arrived. `pop_data` shows the head byte during the read cycle. The count in status bits 7:0 changes one cycle after a push or a read.
- R3: When the queue holds DEPTH bytes, status bit 8 is 1 and status bits 7:0 read as zero.
- R4: A control write with bit 1 set empties the queue and clears data-ready. Any push in that same cycle is discarded. The stored control value keeps every written bit except bit 1, which always reads back as 0.
- R5: In queue mode, data-ready rises when a byte is accepted. A read that leaves the queue empty clears it. A read that leaves bytes behind keeps it set.
- R6: With control bit 0 clear, each push overwrites a single holding register and sets data-ready. A read returns the held byte and clears data-ready. The queue count is not affected.
- R7: In queue mode, a read while the queue is empty returns zero, leaves the count at zero and pulses `ev_err` in the next cycle.
- R8: In queue mode, a push into a full queue without a read is dropped. The stored bytes stay as they were, `ev_err` pulses, error bit 0 (overrun) is set, `ev_rx` stays low and data-ready stays set.
- R9: A push with `push_brk` stores the byte 0x00, whatever `push_data` holds, and sets error bit 3. Any push with `push_perr` sets error bit 1, and any push with `push_ferr` sets error bit 2.
- R10: `err_stat` shows the error word during an `err_rd` cycle. After that edge the word holds only the bits raised in that same cycle.
- R11: `ev_rx` is a one-cycle pulse in the cycle after each accepted push, in either mode. A dropped push gives no pulse.
- R12: In queue mode, a push and a read in the same cycle on a non-empty queue leave the count unchanged and keep both bytes. This holds when the queue is full as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control data: bit 0 enables the queue, bit 1 flushes it |
| ctl_rdata | output | 8 | Stored control value |
| push_valid | input | 1 | Byte from the deserializer, one-cycle strobe |
| push_data | input | 8 | Received byte |
| push_perr | input | 1 | Parity error with this byte |
| push_ferr | input | 1 | Framing error with this byte |
| push_brk | input | 1 | This push reports a line break |
| pop | input | 1 | Data register read strobe |
| pop_data | output | 8 | Byte returned in the read cycle |
| fifo_stat | output | 9 | Bit 8 is full; bits 7:0 are the count, forced to zero when full |
| data_ready | output | 1 | Received data waiting |
| err_rd | input | 1 | Error word read strobe (clears the word) |
| err_stat | output | 4 | Error word: bit 0 overrun, bit 1 parity, bit 2 frame, bit 3 break |
| ev_rx | output | 1 | Accepted-byte event pulse |
| ev_err | output | 1 | Dropped-byte or empty-read event pulse |

## Verification
The assertions assume that every strobe (`push_valid`, `pop`, `err_rd`, `ctl_we`) is a clean level that is sampled once per edge and never X after reset. They also assume that a control write and a push may share a cycle, with the control value in force being the one stored before that edge. The stimulus changes all inputs on falling edges and lowers every strobe right after the rising edge that consumes it. Each strobe is therefore seen for exactly one cycle, and combinational outputs are read only when the inputs are settled.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_DW   = 8;
    localparam int CTL_W    = 8;
    localparam int ERR_W    = 4;
    localparam int STAT_W   = 9;
    // control bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_FLUSH = 1;
    // error word bit positions
    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [RXQ_DW-1:0] hold;
        logic              ready;
        logic              ev_rx;
        logic              ev_err;
    } rxq_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [AW-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [CW-1:0] cnt_d, cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wr_d  = wr_q;
        rd_d  = rd_q;
        cnt_d = cnt_q;
        if (flush) begin
            wr_d  = '0;
            rd_d  = '0;
            cnt_d = '0;
        end else begin
            if (wr_en) wr_d = bump(wr_q);
            if (rd_en) rd_d = bump(rd_q);
            case ({wr_en, rd_en})
                2'b10:   cnt_d = cnt_q + 1'b1;
                2'b01:   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    assign wr_ptr = wr_q;
    assign rd_ptr = rd_q;
    assign count  = cnt_q;
    assign full   = (cnt_q == CW'(DEPTH));
    assign empty  = (cnt_q == '0);
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat #(
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] set,
    input  logic          rd_clr,
    output logic [EW-1:0] q
);
    logic [EW-1:0] err_d, err_q;

    always_comb begin
        if (rd_clr) err_d = set;
        else        err_d = err_q | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign q = err_q;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              push_valid,
    input  logic [RXQ_DW-1:0] push_data,
    input  logic              push_perr,
    input  logic              push_ferr,
    input  logic              push_brk,
    input  logic              pop,
    output logic [RXQ_DW-1:0] pop_data,
    output logic [STAT_W-1:0] fifo_stat,
    output logic              data_ready,
    input  logic              err_rd,
    output logic [ERR_W-1:0]  err_stat,
    output logic              ev_rx,
    output logic              ev_err
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rxq_state_t st_d, st_q;

    logic              fifo_en, flush;
    logic              pop_ok, room, push_ok_f, push_ok_h, drop, empty_rd;
    logic [RXQ_DW-1:0] push_byte, mem_rdata;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     lvl_count;
    logic              lvl_full, lvl_empty;
    logic [ERR_W-1:0]  err_set;

    always_comb begin
        fifo_en   = st_q.ctl[CTL_EN];
        flush     = ctl_we & ctl_wdata[CTL_FLUSH];
        push_byte = push_brk ? '0 : push_data;

        pop_ok    = fifo_en & pop & ~lvl_empty;
        empty_rd  = fifo_en & pop & lvl_empty;
        room      = ~lvl_full | pop_ok;
        push_ok_f = fifo_en & push_valid & room & ~flush;
        drop      = fifo_en & push_valid & ~room & ~flush;
        push_ok_h = ~fifo_en & push_valid & ~flush;

        err_set          = '0;
        err_set[ERR_OVR] = drop;
        err_set[ERR_PAR] = push_valid & push_perr;
        err_set[ERR_FRM] = push_valid & push_ferr;
        err_set[ERR_BRK] = push_valid & push_brk;

        st_d        = st_q;
        st_d.ev_rx  = push_ok_f | push_ok_h;
        st_d.ev_err = drop | empty_rd;
        if (ctl_we) begin
            st_d.ctl            = ctl_wdata;
            st_d.ctl[CTL_FLUSH] = 1'b0;
        end
        if (push_ok_h) begin
            st_d.hold = push_byte;
        end

        if (flush) begin
            st_d.ready = 1'b0;
        end else if (fifo_en) begin
            if (push_ok_f)                              st_d.ready = 1'b1;
            else if (pop_ok && lvl_count == CW'(1))     st_d.ready = 1'b0;
        end else begin
            if (push_ok_h)                              st_d.ready = 1'b1;
            else if (pop)                               st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxq_store #(.DEPTH(DEPTH), .DW(RXQ_DW), .AW(AW)) u_store (
        .clk   (clk),
        .we    (push_ok_f),
        .waddr (wr_ptr),
        .wdata (push_byte),
        .raddr (rd_ptr),
        .rdata (mem_rdata)
    );

    rxq_level #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (push_ok_f),
        .rd_en  (pop_ok),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (lvl_count),
        .full   (lvl_full),
        .empty  (lvl_empty)
    );

    rxq_errstat #(.EW(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (err_set),
        .rd_clr (err_rd),
        .q      (err_stat)
    );

    assign pop_data   = fifo_en ? (lvl_empty ? '0 : mem_rdata) : st_q.hold;
    assign fifo_stat  = {lvl_full, lvl_full ? 8'd0 : 8'(lvl_count)};
    assign data_ready = st_q.ready;
    assign ctl_rdata  = st_q.ctl;
    assign ev_rx      = st_q.ev_rx;
    assign ev_err     = st_q.ev_err;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          flush,
    input logic          push_valid,
    input logic          pop,
    input logic          err_rd,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          empty,
    input logic [7:0]    pop_data,
    input logic [7:0]    ctl_rdata,
    input logic          data_ready,
    input logic [3:0]    err_stat,
    input logic          ev_rx,
    input logic          ev_err
);
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && push_valid && !pop && !flush && !full |=> count == $past(count) + 1'b1);

    a_r12_pushpop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && push_valid && pop && !empty && !flush |=> count == $past(count));

    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && pop && empty |-> pop_data == 8'h00);

    a_r7_empty_read_event: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && pop && empty |=> ev_err);

    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && push_valid && full && !pop && !flush |=> ev_err && !ev_rx && full && data_ready);

    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0 && !data_ready && !ctl_rdata[1]);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        err_rd && !push_valid |=> err_stat == 4'h0);

    a_r11_rx_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |-> $past(push_valid));
endmodule

bind rxq_top rxq_checker #(.CW(CW)) u_rxq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .flush      (flush),
    .push_valid (push_valid),
    .pop        (pop),
    .err_rd     (err_rd),
    .count      (lvl_count),
    .full       (lvl_full),
    .empty      (lvl_empty),
    .pop_data   (pop_data),
    .ctl_rdata  (ctl_rdata),
    .data_ready (data_ready),
    .err_stat   (err_stat),
    .ev_rx      (ev_rx),
    .ev_err     (ev_err)
);

// File: tb/rxq_top_bench.sv
`timescale 1ns/1ps
module rxq_top_bench;
    localparam int CLK_NS = 20;
    localparam int DEPTH  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic [8:0] fifo_stat;
    logic       data_ready;
    logic       err_rd = 1'b0;
    logic [3:0] err_stat;
    logic       ev_rx, ev_err;

    int n_chk  = 0;
    int n_fail = 0;
    logic       done = 1'b0;
    logic [7:0] pre_rd;
    logic [3:0] pre_err;

    always #(CLK_NS/2) clk = ~clk;

    rxq_top #(.DEPTH(DEPTH)) u_rxq_top (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .push_valid(push_valid), .push_data(push_data),
        .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
        .pop(pop), .pop_data(pop_data), .fifo_stat(fifo_stat),
        .data_ready(data_ready), .err_rd(err_rd), .err_stat(err_stat),
        .ev_rx(ev_rx), .ev_err(ev_err)
    );

    // op: 0 push, 1 read, 2 push and read; fields {op, din, exp_rd, exp_cnt, exp_rdy}
    localparam int NV = 9;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 8'h11, 8'h00, 8'd1, 1'b1},
        {2'd0, 8'h22, 8'h00, 8'd2, 1'b1},
        {2'd0, 8'h33, 8'h00, 8'd3, 1'b1},
        {2'd1, 8'h00, 8'h11, 8'd2, 1'b1},
        {2'd2, 8'h44, 8'h22, 8'd2, 1'b1},
        {2'd1, 8'h00, 8'h33, 8'd1, 1'b1},
        {2'd1, 8'h00, 8'h44, 8'd0, 1'b0},
        {2'd0, 8'h55, 8'h00, 8'd1, 1'b1},
        {2'd1, 8'h00, 8'h55, 8'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic pv, input logic [7:0] pd, input logic pe, input logic fe,
                        input logic bk, input logic pp, input logic er,
                        input logic cw, input logic [7:0] cd);
        @(negedge clk);
        push_valid = pv; push_data = pd; push_perr = pe; push_ferr = fe; push_brk = bk;
        pop = pp; err_rd = er; ctl_we = cw; ctl_wdata = cd;
        #2;
        pre_rd  = pop_data;
        pre_err = err_stat;
        @(posedge clk);
        #1;
        push_valid = 1'b0; push_perr = 1'b0; push_ferr = 1'b0; push_brk = 1'b0;
        pop = 1'b0; err_rd = 1'b0; ctl_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);  step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); endtask
    task automatic rd();                       step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00); endtask
    task automatic ctl(input logic [7:0] c);   step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, c); endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 stat", fifo_stat, 0);
        chk("R1 ready", data_ready, 0);
        chk("R1 err", err_stat, 0);
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 events", {ev_rx, ev_err}, 0);
        @(negedge clk); rst_n = 1'b1;

        ctl(8'h01);
        chk("R4 ctl enable stored", ctl_rdata, 8'h01);

        // R2 R5 R12: table of queue traffic
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][26:25];
            step(op != 2'd1, VEC[i][24:17], 1'b0, 1'b0, 1'b0, op != 2'd0, 1'b0, 1'b0, 8'h00);
            if (op != 2'd0) chk("R2 read order", pre_rd, VEC[i][16:9]);
            chk("R2 count", fifo_stat, {1'b0, VEC[i][8:1]});
            chk("R5 ready", data_ready, VEC[i][0]);
            chk("R11 rx event", ev_rx, op != 2'd1);
        end

        // R3: fill to full
        for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i));
        chk("R3 full status", fifo_stat, 9'h100);
        chk("R5 ready at full", data_ready, 1);
        // R8: overflow
        push(8'hEE);
        chk("R8 drop event", ev_err, 1);
        chk("R11 no rx event on drop", ev_rx, 0);
        chk("R8 overrun bit", err_stat, 4'h1);
        chk("R8 still full", fifo_stat, 9'h100);
        chk("R8 ready kept", data_ready, 1);
        // R12: push and read together at full
        step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R12 head at full", pre_rd, 8'h80);
        chk("R12 count kept", fifo_stat, 9'h100);
        chk("R12 accepted", ev_rx, 1);
        for (int i = 1; i < DEPTH; i++) begin
            rd();
            chk("R8 contents intact", pre_rd, 8'h80 + 8'(i));
        end
        rd();
        chk("R12 last byte kept", pre_rd, 8'h77);
        chk("R5 ready clears on last", data_ready, 0);

        // R7: read while empty
        rd();
        chk("R7 empty read data", pre_rd, 8'h00);
        chk("R7 error event", ev_err, 1);
        chk("R7 count stays", fifo_stat, 9'h000);

        // R10: read-to-clear
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R10 value during read", pre_err, 4'h1);
        chk("R10 cleared after read", err_stat, 4'h0);

        // R9: break stores zero byte
        step(1'b1, 8'hAB, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R9 break bit", err_stat, 4'h8);
        rd();
        chk("R9 break byte is zero", pre_rd, 8'h00);
        step(1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R9 parity bit", err_stat, 4'hA);
        step(1'b1, 8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R9 frame bit", err_stat, 4'hE);
        step(1'b1, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R10 read shows word", pre_err, 4'hE);
        chk("R10 same-cycle bit kept", err_stat, 4'h2);

        // R4: flush with self-clearing bit
        push(8'h10);
        chk("R4 count before flush", fifo_stat, 9'h004);
        ctl(8'h03);
        chk("R4 flushed count", fifo_stat, 9'h000);
        chk("R4 ready cleared", data_ready, 0);
        chk("R4 flush bit not stored", ctl_rdata, 8'h01);
        rd();
        chk("R4 nothing left", pre_rd, 8'h00);

        // R6: holding register mode
        ctl(8'h00);
        push(8'h5A);
        chk("R6 ready set", data_ready, 1);
        chk("R11 rx event hold mode", ev_rx, 1);
        push(8'h6B);
        rd();
        chk("R6 newest byte", pre_rd, 8'h6B);
        chk("R6 ready cleared", data_ready, 0);
        chk("R6 queue untouched", fifo_stat, 9'h000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule